// File: doc/BRIEF.md
# Interrupt Priority Arbiter with Base-Priority Masking

This block is the decision core of a small interrupt controller. A parameterised set of interrupt sources each hold a pending bit and an 8-bit priority. The pending source with the most urgent priority is chosen. That choice passes through two thresholds before it becomes the current-pending interrupt. One is a global priority mask. The other is a programmable base-priority level that blocks everything at or below it. The current-pending interrupt is requested from the processor only when it is more urgent than the exception that is already running.

Priority numbers are inverted: a smaller value is more urgent. Software writes the base-priority level through a small write port that has two modes. A plain write always loads the value. A tightening write may only make the mask stricter. Acknowledge and complete pulses track the running priority.

Every pin is a plain control or status signal. There is no streaming data path, so the block has no valid/ready handshake and applies no back-pressure. A write or pulse takes effect on the clock edge where it is sampled high.

Top module: `irq_prio_core`

## Requirements
- R1: Among pending sources the one with the smallest priority value is selected. On equal values the lowest source index wins, and `irq_id`/`irq_prio` report it.
- R2: A base-priority write keeps only bits [7:0] of `bp_wdata`. The upper bits are discarded.
- R3: A base-priority value of 0 applies no masking.
- R4: With a nonzero base priority, the selection is current-pending (`irq_valid`) only if its value is strictly below the base priority.
- R5: The selection is current-pending only if its value is strictly below the 9-bit global mask, in addition to R4.
- R6: `irq_req` is high only when `irq_valid` is high and the selected value is strictly below `running_prio`.
- R7: With `bp_max`=1, the write loads only if the truncated value is nonzero and either the stored value is 0 or the new value is smaller. Otherwise the stored value is unchanged.
- R8: After reset the base priority is 0, the global mask is 0x100, `running_prio` is 0x100, all pending bits are clear and all priorities are 0. With no mask write, even priority 0xFF is current-pending.
- R9: Writing the value already held leaves `bp_value` and the arbitration outputs unchanged.
- R10: `ack` while `irq_req` is high loads `running_prio` with `irq_prio` and clears the pending bit of `irq_id`. A `pend_set` in the same cycle wins for its own bit.
- R11: `cmpl` returns `running_prio` to 0x100. It overrides a simultaneous `ack`.
- R12: The arbitration outputs are registered. A change to the pending bits, priorities, mask or base priority appears on them one clock after the edge that stored it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pend_set | input | NUM_IRQ | Per-source set of the pending bit (wins over clear) |
| pend_clr | input | NUM_IRQ | Per-source clear of the pending bit |
| prio_we | input | 1 | Priority write strobe |
| prio_idx | input | IDW | Source index for the priority write |
| prio_wdata | input | 8 | Priority value to store |
| mask_we | input | 1 | Global mask write strobe |
| mask_wdata | input | 9 | Global mask value |
| bp_we | input | 1 | Base-priority write strobe |
| bp_max | input | 1 | 0 = plain write, 1 = tighten-only write |
| bp_wdata | input | 32 | Base-priority write data (low 8 bits used) |
| ack | input | 1 | Acknowledge the requested interrupt |
| cmpl | input | 1 | Complete the running exception |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_valid | output | 1 | A current-pending interrupt exists |
| irq_id | output | IDW | Index of the selected source |
| irq_prio | output | 8 | Priority of the selected source |
| bp_value | output | 8 | Stored base priority |
| running_prio | output | 9 | Priority of the running exception (0x100 idle) |

## Verification
The bench builds the core with NUM_IRQ=4, so it can drive all sixteen pending patterns. The four priorities include a tie and sit just around the threshold values. Every pattern is crossed with mask values and base-priority values placed at, one above and far from those priorities, which exercises each strict-less-than edge. The bench also walks the tightening-write rules one case at a time and runs the acknowledge/complete sequence, including a source whose priority equals the running priority.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int PRIO_W = 8;
  localparam int RUN_W  = PRIO_W + 1;
  localparam logic [RUN_W-1:0] IDLE_LEVEL = RUN_W'(1) << PRIO_W;

  typedef enum logic {
    BP_PLAIN = 1'b0,
    BP_TIGHT = 1'b1
  } bp_mode_e;
endpackage

// File: rtl/irq_pend_store.sv
module irq_pend_store
  import irq_prio_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int IDW     = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_IRQ-1:0]              pend_set,
  input  logic [NUM_IRQ-1:0]              pend_clr,
  input  logic                            ack_clr,
  input  logic [IDW-1:0]                  ack_idx,
  input  logic                            prio_we,
  input  logic [IDW-1:0]                  prio_idx,
  input  logic [PRIO_W-1:0]               prio_wdata,
  output logic [NUM_IRQ-1:0]              pend_q,
  output logic [NUM_IRQ-1:0][PRIO_W-1:0]  prio_q
);

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_src
    logic drop;
    assign drop = pend_clr[g] || (ack_clr && (ack_idx == IDW'(g)));

    always_ff @(posedge clk) begin
      if (!rst_n)          pend_q[g] <= 1'b0;
      else if (pend_set[g]) pend_q[g] <= 1'b1;
      else if (drop)        pend_q[g] <= 1'b0;
    end

    always_ff @(posedge clk) begin
      if (!rst_n)                                  prio_q[g] <= '0;
      else if (prio_we && (prio_idx == IDW'(g)))   prio_q[g] <= prio_wdata;
    end

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend_set[g] |=> pend_q[g]);
  end

endmodule

// File: rtl/irq_min_select.sv
module irq_min_select
  import irq_prio_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int IDW     = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_IRQ-1:0]              pend,
  input  logic [NUM_IRQ-1:0][PRIO_W-1:0]  prio,
  output logic                            found,
  output logic [IDW-1:0]                  win_idx,
  output logic [PRIO_W-1:0]               win_prio
);

  always_comb begin
    found    = 1'b0;
    win_idx  = '0;
    win_prio = '1;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (pend[i] && (!found || (prio[i] < win_prio))) begin
        found    = 1'b1;
        win_idx  = IDW'(i);
        win_prio = prio[i];
      end
    end
  end

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_ord
    // R1
    min_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend[g] |-> found && ((prio[g] > win_prio) ||
                            ((prio[g] == win_prio) && (IDW'(g) >= win_idx))));
  end

endmodule

// File: rtl/irq_basepri_reg.sv
module irq_basepri_reg
  import irq_prio_pkg::*;
#(
  parameter int WR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  bp_mode_e          mode,
  input  logic [WR_W-1:0]   wdata,
  output logic [PRIO_W-1:0] bp_q
);

  logic [PRIO_W-1:0] trunc;
  logic              unused_hi;
  logic              accept;
  logic              changed;

  assign trunc     = wdata[PRIO_W-1:0];
  assign unused_hi = ^wdata[WR_W-1:PRIO_W];

  always_comb begin
    accept = 1'b0;
    unique case (mode)
      BP_PLAIN: accept = 1'b1;
      BP_TIGHT: accept = (trunc != '0) && ((bp_q == '0) || (trunc < bp_q));
      default:  accept = 1'b0;
    endcase
  end

  assign changed = we && accept && (trunc != bp_q);

  always_ff @(posedge clk) begin
    if (!rst_n)       bp_q <= '0;
    else if (changed) bp_q <= trunc;
  end

  // R7
  tight_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (mode == BP_TIGHT)) |=>
      (bp_q == $past(bp_q)) ||
      ((bp_q != '0) && (($past(bp_q) == '0) || (bp_q < $past(bp_q)))));

  // R9
  same_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (trunc == bp_q)) |=> $stable(bp_q));

  // R2
  plain_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (mode == BP_PLAIN)) |=> (bp_q == $past(trunc)));

endmodule

// File: rtl/irq_prio_core.sv
module irq_prio_core
  import irq_prio_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int WR_W    = 32,
  localparam int IDW    = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_IRQ-1:0]   pend_set,
  input  logic [NUM_IRQ-1:0]   pend_clr,
  input  logic                 prio_we,
  input  logic [IDW-1:0]       prio_idx,
  input  logic [PRIO_W-1:0]    prio_wdata,
  input  logic                 mask_we,
  input  logic [RUN_W-1:0]     mask_wdata,
  input  logic                 bp_we,
  input  logic                 bp_max,
  input  logic [WR_W-1:0]      bp_wdata,
  input  logic                 ack,
  input  logic                 cmpl,
  output logic                 irq_req,
  output logic                 irq_valid,
  output logic [IDW-1:0]       irq_id,
  output logic [PRIO_W-1:0]    irq_prio,
  output logic [PRIO_W-1:0]    bp_value,
  output logic [RUN_W-1:0]     running_prio
);

  logic [NUM_IRQ-1:0]             pend_q;
  logic [NUM_IRQ-1:0][PRIO_W-1:0] prio_q;
  logic                           sel_found;
  logic [IDW-1:0]                 sel_idx;
  logic [PRIO_W-1:0]              sel_prio;
  logic [RUN_W-1:0]               mask_q;
  logic [RUN_W-1:0]               run_q;
  logic                           ack_fire;
  logic                           pass_mask;
  logic                           pass_bp;
  logic                           valid_d;
  logic                           req_d;
  bp_mode_e                       bp_mode;

  assign ack_fire = ack && irq_req && !cmpl;
  assign bp_mode  = bp_max ? BP_TIGHT : BP_PLAIN;

  irq_pend_store #(.NUM_IRQ(NUM_IRQ), .IDW(IDW)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .pend_set   (pend_set),
    .pend_clr   (pend_clr),
    .ack_clr    (ack_fire),
    .ack_idx    (irq_id),
    .prio_we    (prio_we),
    .prio_idx   (prio_idx),
    .prio_wdata (prio_wdata),
    .pend_q     (pend_q),
    .prio_q     (prio_q)
  );

  irq_min_select #(.NUM_IRQ(NUM_IRQ), .IDW(IDW)) u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .pend     (pend_q),
    .prio     (prio_q),
    .found    (sel_found),
    .win_idx  (sel_idx),
    .win_prio (sel_prio)
  );

  irq_basepri_reg #(.WR_W(WR_W)) u_bp (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (bp_we),
    .mode  (bp_mode),
    .wdata (bp_wdata),
    .bp_q  (bp_value)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= IDLE_LEVEL;
    else if (mask_we) mask_q <= mask_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        run_q <= IDLE_LEVEL;
    else if (cmpl)     run_q <= IDLE_LEVEL;
    else if (ack_fire) run_q <= {1'b0, irq_prio};
  end
  assign running_prio = run_q;

  assign pass_mask = {1'b0, sel_prio} < mask_q;
  assign pass_bp   = (bp_value == '0) || (sel_prio < bp_value);
  assign valid_d   = sel_found && pass_mask && pass_bp;
  assign req_d     = valid_d && ({1'b0, sel_prio} < run_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_valid <= 1'b0;
      irq_req   <= 1'b0;
      irq_id    <= '0;
      irq_prio  <= '0;
    end else begin
      irq_valid <= valid_d;
      irq_req   <= req_d;
      irq_id    <= sel_idx;
      irq_prio  <= sel_prio;
    end
  end

  // R5
  valid_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> ({1'b0, irq_prio} < $past(mask_q)));

  // R4
  valid_bp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && ($past(bp_value) != '0)) |-> (irq_prio < $past(bp_value)));

  // R6
  req_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_valid && ({1'b0, irq_prio} < $past(run_q))));

  // R11
  cmpl_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl |=> (run_q == IDLE_LEVEL));

  // R10
  ack_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_req && !cmpl) |=> (run_q == {1'b0, $past(irq_prio)}));

endmodule

// File: tb/sim_irq_prio_core.sv
module sim_irq_prio_core;
  localparam int CLK_PERIOD = 10;
  localparam int N   = 4;
  localparam int IDW = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] pend_set = '0, pend_clr = '0;
  logic         prio_we = 1'b0;
  logic [IDW-1:0] prio_idx = '0;
  logic [7:0]   prio_wdata = '0;
  logic         mask_we = 1'b0;
  logic [8:0]   mask_wdata = '0;
  logic         bp_we = 1'b0, bp_max = 1'b0;
  logic [31:0]  bp_wdata = '0;
  logic         ack = 1'b0, cmpl = 1'b0;
  logic         irq_req, irq_valid;
  logic [IDW-1:0] irq_id;
  logic [7:0]   irq_prio, bp_value;
  logic [8:0]   running_prio;

  int checks = 0;
  int errors = 0;

  logic [7:0] m_prio [N];
  logic [N-1:0] m_pend;
  logic [8:0] m_mask, m_run;
  logic [7:0] m_bp;

  irq_prio_core #(.NUM_IRQ(N), .WR_W(32)) u0 (
    .clk(clk), .rst_n(rst_n), .pend_set(pend_set), .pend_clr(pend_clr),
    .prio_we(prio_we), .prio_idx(prio_idx), .prio_wdata(prio_wdata),
    .mask_we(mask_we), .mask_wdata(mask_wdata), .bp_we(bp_we),
    .bp_max(bp_max), .bp_wdata(bp_wdata), .ack(ack), .cmpl(cmpl),
    .irq_req(irq_req), .irq_valid(irq_valid), .irq_id(irq_id),
    .irq_prio(irq_prio), .bp_value(bp_value), .running_prio(running_prio)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_arb(string tag);
    bit found = 0;
    int wi = 0;
    logic [7:0] wp = 0;
    bit ev, er;
    for (int i = 0; i < N; i++)
      if (m_pend[i] && (!found || m_prio[i] < wp)) begin
        found = 1; wi = i; wp = m_prio[i];
      end
    ev = found && ({1'b0, wp} < m_mask) && (m_bp == 0 || wp < m_bp);
    er = ev && ({1'b0, wp} < m_run);
    if (ev)
      chk(tag, {irq_valid, irq_req, 6'(irq_id), irq_prio},
               {1'b1, er, 6'(wi), wp});
    else
      chk(tag, {irq_valid, irq_req}, {1'b0, 1'b0});
  endtask

  task automatic wr_prio(int idx, logic [7:0] v);
    @(negedge clk); prio_we = 1; prio_idx = IDW'(idx); prio_wdata = v;
    @(negedge clk); prio_we = 0;
    @(negedge clk);
    m_prio[idx] = v;
  endtask

  task automatic wr_mask(logic [8:0] v);
    @(negedge clk); mask_we = 1; mask_wdata = v;
    @(negedge clk); mask_we = 0;
    @(negedge clk);
    m_mask = v;
  endtask

  task automatic wr_bp(bit tight, logic [31:0] v);
    logic [7:0] t = v[7:0];
    @(negedge clk); bp_we = 1; bp_max = tight; bp_wdata = v;
    @(negedge clk); bp_we = 0; bp_max = 0;
    @(negedge clk);
    if (!tight) m_bp = t;
    else if (t != 0 && (m_bp == 0 || t < m_bp)) m_bp = t;
  endtask

  task automatic put_pend(logic [N-1:0] pat);
    @(negedge clk); pend_clr = '1; pend_set = pat;
    @(negedge clk); pend_clr = '0; pend_set = '0;
    @(negedge clk);
    m_pend = pat;
  endtask

  initial begin
    logic [8:0] mask_list [4] = '{9'h100, 9'h020, 9'h021, 9'h041};
    logic [7:0] bp_list [8] = '{8'h00, 8'h01, 8'h20, 8'h21, 8'h40, 8'h41, 8'h80, 8'hFF};
    for (int i = 0; i < N; i++) m_prio[i] = 0;
    m_pend = 0; m_mask = 9'h100; m_run = 9'h100; m_bp = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R8 reset state
    chk("R8 req", irq_req, 0);
    chk("R8 valid", irq_valid, 0);
    chk("R8 bp", bp_value, 0);
    chk("R8 run", running_prio, 9'h100);
    wr_prio(2, 8'hFF);
    put_pend(4'b0100);
    chk("R8 mask 0x100 passes 0xFF", {irq_valid, irq_req}, 2'b11);

    // R12 one-clock latency
    @(negedge clk); pend_clr = '1; pend_set = 4'b0001;
    @(negedge clk); pend_clr = '0; pend_set = '0;
    chk("R12 before", irq_id, 2);
    @(negedge clk);
    chk("R12 after", irq_id, 0);
    m_pend = 4'b0001;

    // R1 R3 R4 R5 sweep
    wr_prio(0, 8'h40); wr_prio(1, 8'h20); wr_prio(2, 8'h80); wr_prio(3, 8'h20);
    foreach (mask_list[mi]) begin
      wr_mask(mask_list[mi]);
      foreach (bp_list[bi]) begin
        wr_bp(0, {24'h0, bp_list[bi]});
        for (int p = 0; p < 16; p++) begin
          put_pend(4'(p));
          check_arb("R1/R3/R4/R5 sweep");
        end
      end
    end
    wr_mask(9'h100);

    // R2 truncation
    wr_bp(0, 32'hDEAD_01A5);
    chk("R2 trunc", bp_value, 8'hA5);
    wr_bp(0, 0);
    chk("R3 plain zero", bp_value, 0);
    // R7 tighten-only
    wr_bp(1, 32'h40); chk("R7 from zero", bp_value, 8'h40);
    wr_bp(1, 32'h60); chk("R7 looser ignored", bp_value, 8'h40);
    wr_bp(1, 32'h20); chk("R7 tighter", bp_value, 8'h20);
    wr_bp(1, 32'h0);  chk("R7 zero ignored", bp_value, 8'h20);
    wr_bp(1, 32'h100); chk("R7 trunc zero ignored", bp_value, 8'h20);
    wr_bp(1, 32'h120); chk("R7 equal ignored", bp_value, 8'h20);
    wr_bp(1, 32'h11F); chk("R7 trunc tighter", bp_value, 8'h1F);

    // R9 same value
    wr_bp(0, 32'h30);
    put_pend(4'b0010);
    check_arb("R9 before");
    wr_bp(0, 32'h30);
    chk("R9 bp", bp_value, 8'h30);
    check_arb("R9 plain same");
    wr_bp(1, 32'h30);
    chk("R9 bp tight", bp_value, 8'h30);
    check_arb("R9 tight same");
    wr_bp(0, 0);

    // R10 R6 R11
    put_pend(4'b0001);
    check_arb("R10 setup");
    @(negedge clk); ack = 1;
    @(negedge clk); ack = 0;
    @(negedge clk);
    m_run = 9'h040; m_pend = 4'b0000;
    chk("R10 run", running_prio, 9'h040);
    chk("R10 pend cleared", irq_valid, 0);
    wr_prio(2, 8'h40);
    put_pend(4'b0100);
    chk("R6 equal no req", {irq_valid, irq_req}, 2'b10);
    check_arb("R6 equal");
    wr_prio(3, 8'h3F);
    put_pend(4'b1000);
    chk("R6 more urgent req", {irq_valid, irq_req}, 2'b11);
    @(negedge clk); cmpl = 1; ack = 1;
    @(negedge clk); cmpl = 0; ack = 0;
    @(negedge clk);
    m_run = 9'h100;
    chk("R11 run idle", running_prio, 9'h100);
    chk("R11 ack overridden pend kept", irq_valid, 1);
    check_arb("R11 after");

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule